// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block joins two 18-bit tri-state ports, A and B, with one storage element for each direction. A-to-B and B-to-A have the same structure and separate controls: a latch enable, a direction clock, an active-low clock enable and an active-low output enable. The storage element takes one of three roles. While the latch enable is high it passes data through. While the latch enable is low and no clock edge arrives it holds its value. While the latch enable is low and a qualified rising edge of the direction clock arrives it captures a new value.

The whole block runs on one system clock. The storage element samples the source port on every system clock edge. The direction clock is treated as a level that is sampled on the system clock, and a rising edge is a sample of 0 followed by a sample of 1. Each port is split into an input bus, an output-data bus and an output-enable line, so that the tri-state buffer can sit at the pad level.

Top module: `bus_xcvr`

## Requirements
- R1: Both directions are DATA_W (default 18) bits wide and work independently: A-to-B storage uses only a_i and the AB controls, and B-to-A storage uses only b_i and the BA controls.
- R2: When a direction's latch enable is 1 at a system clock edge, the storage takes the source input sampled at that edge, and the destination output shows that value after the edge.
- R3: When the latch enable is 0 and no rising edge of the direction clock is detected at a system clock edge, the stored value does not change. This holds whether the direction clock stays at 0 or at 1.
- R4: A rising edge of the direction clock is detected at a system clock edge where the clock is sampled 1 and was sampled 0 at the previous system clock edge. With the latch enable at 0 and the clock enable at 0 (active), that edge captures the source input sampled at the same edge.
- R5: When the clock enable is 1 (inactive), a detected rising edge does not capture, and the stored value is kept.
- R6: The output enable of each direction is active low. The destination port's output-enable line is 1 exactly when that input is 0. The output data always shows the stored value.
- R7: The storage keeps updating through pass-through and capture while its output enable is 1. The new value appears on the output data once the output is enabled again.
- R8: When the latch enable falls from 1 to 0, the storage keeps the last value it took while the latch enable was 1.
- R9: An active-low asynchronous reset clears both stored values to 0 and clears the sampled direction-clock history to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 18 | A port input data |
| a_o | output | 18 | A port output data (B-to-A storage) |
| a_oe_o | output | 1 | A port driver enable |
| b_i | input | 18 | B port input data |
| b_o | output | 18 | B port output data (A-to-B storage) |
| b_oe_o | output | 1 | B port driver enable |
| ab_oe_ni | input | 1 | A-to-B output enable, active low |
| ab_le_i | input | 1 | A-to-B latch enable |
| ab_clk_i | input | 1 | A-to-B direction clock (level, sampled) |
| ab_ce_ni | input | 1 | A-to-B clock enable, active low |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| ba_le_i | input | 1 | B-to-A latch enable |
| ba_clk_i | input | 1 | B-to-A direction clock (level, sampled) |
| ba_ce_ni | input | 1 | B-to-A clock enable, active low |

## Verification
The hardest case to reach is a capture that depends on what happened on the previous cycle. A rising edge counts only if the direction clock was low at the previous sample, and it must line up with latch enable low and clock enable in a chosen state. The direction clock is also a level that can stay high for many cycles, and none of those cycles may capture. Directed sequences step the direction clock low and then high with the clock enable both active and inactive, and they hold it high for several cycles while the source data changes. A seeded random phase then toggles all controls of both directions on every cycle. A bench model that keeps its own record of the previous clock sample predicts every output.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  localparam int unsigned DIRS = 2;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_PASS = 2'd1,
    MODE_CAPT = 2'd2
  } xfer_mode_e;
endpackage

// File: rtl/bus_xcvr_edge.sv
module bus_xcvr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/bus_xcvr_lane.sv
module bus_xcvr_lane
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] src_i,
  input  logic              le_i,
  input  logic              rise_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] dst_o,
  output logic              dst_oe_o
);
  xfer_mode_e        mode;
  logic [DATA_W-1:0] store_q;

  always_comb begin
    if (le_i)                 mode = MODE_PASS;
    else if (rise_i && !ce_ni) mode = MODE_CAPT;
    else                      mode = MODE_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                store_q <= '0;
    else if (mode != MODE_HOLD) store_q <= src_i;
  end

  assign dst_o    = store_q;
  assign dst_oe_o = ~oe_ni;

  assert_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> store_q == $past(src_i));
  // R3 and R8: no edge with latch closed keeps the value
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !rise_i) |=> $stable(store_q));
  assert_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && rise_i && !ce_ni) |=> store_q == $past(src_i));
  assert_ce_block_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && ce_ni) |=> $stable(store_q));
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] a_o,
  output logic              a_oe_o,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] b_o,
  output logic              b_oe_o,
  input  logic              ab_oe_ni,
  input  logic              ab_le_i,
  input  logic              ab_clk_i,
  input  logic              ab_ce_ni,
  input  logic              ba_oe_ni,
  input  logic              ba_le_i,
  input  logic              ba_clk_i,
  input  logic              ba_ce_ni
);
  // index 0: A to B, index 1: B to A
  logic [DIRS-1:0][DATA_W-1:0] src, dst;
  logic [DIRS-1:0]             le, dclk, ce_n, oe_n, oe, rise;

  assign src  = {b_i, a_i};
  assign le   = {ba_le_i, ab_le_i};
  assign dclk = {ba_clk_i, ab_clk_i};
  assign ce_n = {ba_ce_ni, ab_ce_ni};
  assign oe_n = {ba_oe_ni, ab_oe_ni};

  for (genvar d = 0; d < DIRS; d++) begin : g_dir
    bus_xcvr_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (dclk[d]),
      .rise_o (rise[d])
    );

    bus_xcvr_lane #(.DATA_W(DATA_W)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src[d]),
      .le_i     (le[d]),
      .rise_i   (rise[d]),
      .ce_ni    (ce_n[d]),
      .oe_ni    (oe_n[d]),
      .dst_o    (dst[d]),
      .dst_oe_o (oe[d])
    );
  end

  assign b_o    = dst[0];
  assign b_oe_o = oe[0];
  assign a_o    = dst[1];
  assign a_oe_o = oe[1];

  // R1: the A-to-B output never follows b_i alone while held
  assert_indep_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_le_i && !ab_clk_i) |=> $stable(b_o));
endmodule

// File: tb/sim_bus_xcvr.sv
module sim_bus_xcvr;
  localparam int W = 18;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0, a_o, b_o;
  logic a_oe_o, b_oe_o;
  logic ab_oe_ni = 1'b1, ab_le_i = 1'b0, ab_clk_i = 1'b0, ab_ce_ni = 1'b1;
  logic ba_oe_ni = 1'b1, ba_le_i = 1'b0, ba_clk_i = 1'b0, ba_ce_ni = 1'b1;

  int total = 0, bad = 0;
  logic [W-1:0] exp_ab = '0, exp_ba = '0;
  logic pv_ab = 1'b0, pv_ba = 1'b0;
  string tag_ab = "R3", tag_ba = "R3";

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_xcvr #(.DATA_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe_o),
    .b_i(b_i), .b_o(b_o), .b_oe_o(b_oe_o),
    .ab_oe_ni(ab_oe_ni), .ab_le_i(ab_le_i), .ab_clk_i(ab_clk_i), .ab_ce_ni(ab_ce_ni),
    .ba_oe_ni(ba_oe_ni), .ba_le_i(ba_le_i), .ba_clk_i(ba_clk_i), .ba_ce_ni(ba_ce_ni)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // next stored value and requirement tag for one direction
  function automatic logic [W-1:0] nxt(input logic [W-1:0] cur, input logic [W-1:0] src,
                                       input logic le, input logic ck, input logic pv,
                                       input logic ce_n);
    if (le) return src;
    if (ck && !pv && !ce_n) return cur == cur ? src : src;
    return cur;
  endfunction

  function automatic string tg(input logic le, input logic ck, input logic pv,
                               input logic ce_n, input logic oe_n);
    bit upd;
    string t;
    upd = le || (ck && !pv && !ce_n);
    if (le) t = "R2";
    else if (ck && !pv) t = ce_n ? "R5" : "R4";
    else t = "R3";
    if (oe_n && upd) t = "R7";
    return t;
  endfunction

  task automatic tick();
    @(posedge clk);
    tag_ab = tg(ab_le_i, ab_clk_i, pv_ab, ab_ce_ni, ab_oe_ni);
    tag_ba = tg(ba_le_i, ba_clk_i, pv_ba, ba_ce_ni, ba_oe_ni);
    exp_ab = nxt(exp_ab, a_i, ab_le_i, ab_clk_i, pv_ab, ab_ce_ni);
    exp_ba = nxt(exp_ba, b_i, ba_le_i, ba_clk_i, pv_ba, ba_ce_ni);
    pv_ab = ab_clk_i;
    pv_ba = ba_clk_i;
    @(negedge clk);
    chk(b_o == exp_ab, tag_ab, b_o, exp_ab);
    chk(a_o == exp_ba, tag_ba, a_o, exp_ba);
    chk(b_oe_o == !ab_oe_ni, "R6", {17'd0, b_oe_o}, {17'd0, !ab_oe_ni});
    chk(a_oe_o == !ba_oe_ni, "R6", {17'd0, a_oe_o}, {17'd0, !ba_oe_ni});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    chk(b_o == '0, "R9", b_o, '0);
    chk(a_o == '0, "R9", a_o, '0);
    rst_ni = 1'b1;

    // R2 transparent both ways, distinct data (R1)
    ab_le_i = 1; ba_le_i = 1; ab_oe_ni = 0; ba_oe_ni = 0;
    a_i = 18'h2A5A5; b_i = 18'h15A5A;
    tick();
    chk(b_o == 18'h2A5A5, "R2", b_o, 18'h2A5A5);
    chk(a_o == 18'h15A5A, "R1", a_o, 18'h15A5A);

    // R8 latch closes, later data ignored (clock held low, R3)
    ab_le_i = 0; ba_le_i = 0;
    a_i = 18'h00001; b_i = 18'h3FFFF;
    tick(); tick();
    chk(b_o == 18'h2A5A5, "R8", b_o, 18'h2A5A5);
    chk(a_o == 18'h15A5A, "R8", a_o, 18'h15A5A);

    // R4 capture on AB, BA clock enable off (R5)
    ab_ce_ni = 0; ba_ce_ni = 1;
    ab_clk_i = 1; ba_clk_i = 1;
    a_i = 18'h12345; b_i = 18'h0BEEF;
    tick();
    chk(b_o == 18'h12345, "R4", b_o, 18'h12345);
    chk(a_o == 18'h15A5A, "R5", a_o, 18'h15A5A);

    // R3 clock held high: no further capture
    a_i = 18'h0AAAA; ba_ce_ni = 0;
    tick(); tick();
    chk(b_o == 18'h12345, "R3", b_o, 18'h12345);
    chk(a_o == 18'h15A5A, "R3", a_o, 18'h15A5A);

    // R7 update while disabled, BA captures
    ab_oe_ni = 1; ba_oe_ni = 1;
    ab_clk_i = 0; ba_clk_i = 0;
    tick();
    ab_clk_i = 1; ba_clk_i = 1; a_i = 18'h3C3C3; b_i = 18'h01111;
    tick();
    chk(b_oe_o == 1'b0, "R6", {17'd0, b_oe_o}, '0);
    ab_oe_ni = 0; ba_oe_ni = 0;
    tick();
    chk(b_o == 18'h3C3C3, "R7", b_o, 18'h3C3C3);
    chk(a_o == 18'h01111, "R7", a_o, 18'h01111);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      a_i = W'($urandom); b_i = W'($urandom);
      ab_le_i = ($urandom % 4) == 0; ba_le_i = ($urandom % 4) == 0;
      ab_clk_i = $urandom % 2; ba_clk_i = $urandom % 2;
      ab_ce_ni = ($urandom % 3) == 0; ba_ce_ni = ($urandom % 3) == 0;
      ab_oe_ni = ($urandom % 4) == 0; ba_oe_ni = ($urandom % 4) == 0;
      tick();
    end

    // R9 asynchronous reset mid-run
    #1 rst_ni = 0;
    #1 chk(b_o == '0, "R9", b_o, '0);
    chk(a_o == '0, "R9", a_o, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule